// File: doc/BRIEF.md
# Two-Bus Multicycle Byte Processor Core

This core executes a small accumulate-style instruction set (ADD, AND, OR and a base-register load) over an external byte-addressed memory. Inside, two internal buses carry operands: bus a feeds one ALU input directly and bus b feeds the other through a select that can also supply a constant zero. The ALU result always lands in temporary T1. T2 holds a computed memory address until write-back. The programmer sees four general registers, a base register and a program counter.

Registers place their values on the internal buses at the falling clock edge, and registers capture from the buses at the rising edge. So each state of the sequencer uses one full clock period: the drive happens in the first half and the capture at the end. The address and write-data outputs are tri-state and float whenever the core does not drive them. Memory sits outside the core. A read strobe asks it to return the byte at the driven address in the same cycle. A write strobe marks a cycle in which address and data are valid for a store.

Top module: `cisc_exec_core`

## Requirements
- R1: While reset is held and after it is released, rd_o and wr_o are low until the first falling edge. The first cycle after release is an instruction fetch from address 0 with rd_o high.
- R2: An opcode byte splits into operation bits [7:6] (00 ADD, 01 AND, 10 OR, 11 base load), mode bits [5:4], register-operand bits [3:2] and source/pointer bits [1:0]. Mode 00 computes reg[3:2] = reg[3:2] op reg[1:0] in 3 cycles, with no memory access after the fetch.
- R3: Mode 01 reads mem[reg[1:0]], computes reg[3:2] op that byte and writes the result back to the same address. It takes 5 cycles, and the write strobe comes in the last one.
- R4: Mode 10 takes a second byte as an unsigned displacement. The address is base + displacement modulo 256, and the result reg[3:2] op mem[address] is stored there. It takes 6 cycles.
- R5: Operation 11 loads the base register from the byte that follows the opcode, ignoring bits [5:0]. It takes 3 cycles and performs no write.
- R6: Mode 11 (with operation 00 to 10) reads mem[reg[1:0]] and writes reg[3:2] op that byte into reg[3:2]. It takes 5 cycles and performs no write.
- R7: ADD wraps modulo 2^8 in two's complement. AND and OR are bitwise.
- R8: rd_o and wr_o are never high together. wr_o lasts exactly one cycle, and each write is preceded two cycles earlier by an operand read.
- R9: The program counter advances by one for each byte fetched, so instructions run back to back. The cycle after a write is always the next fetch.
- R10: Address, data and strobe outputs change only at the falling clock edge and stay stable across the rising edge that completes the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; falling edge drives buses, rising edge captures |
| rst_n | input | 1 | Asynchronous active-low reset |
| dat_i | input | W | Byte returned by memory during a read strobe |
| dat_o | output | W | Store data, high-impedance unless writing |
| addr_o | output | W | Memory address, high-impedance unless reading or writing |
| rd_o | output | 1 | Read strobe (instruction, displacement or operand) |
| wr_o | output | 1 | Write strobe for a memory-destination result |

## Verification
A register-to-register instruction or a base load lasts 3 cycles. The indirect forms (memory destination or register destination) last 5, and the displacement form lasts 6. Any store appears in the last cycle of its instruction. The bench runs an instruction-level model of the program ahead of time, adds up these latencies and queues every store with the cycle index in which it must occur. The monitor counts cycles from reset release and samples two nanoseconds before each rising edge, where the falling-edge outputs have settled. It matches address, data and cycle number, then samples again just after the rising edge to confirm the outputs did not move.

// File: rtl/cisc_exec_core.sv
module cisc_exec_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] dat_o,
  output logic [W-1:0] addr_o,
  output logic         rd_o,
  output logic         wr_o
);
  typedef enum logic [2:0] {S_FETCH, S_DISP, S_ADDR, S_READ, S_EXEC, S_WB} state_t;
  localparam logic [1:0] OP_ADD = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_LBI = 2'd3;
  localparam logic [1:0] M_REG = 2'd0, M_IND = 2'd1, M_BASE = 2'd2;

  state_t       state;
  logic [7:0]   ir;
  logic [W-1:0] pc, di, t1, t2, base;
  logic [W-1:0] gpr [4];
  logic [W-1:0] bus_a, bus_b, ao, alu_b, alu_y;
  logic         ao_en, do_en;
  logic [1:0]   fn;

  wire [1:0] f_op  = ir[7:6];
  wire [1:0] f_md  = ir[5:4];
  wire [1:0] f_dst = ir[3:2];
  wire [1:0] f_src = ir[1:0];
  wire       mem_dst = (f_md == M_IND) || (f_md == M_BASE);

  assign addr_o = ao_en ? ao : {W{1'bz}};
  assign dat_o  = do_en ? bus_b : {W{1'bz}};

  always_comb begin
    alu_b = bus_b;
    fn    = f_op;
    if (state == S_ADDR) begin
      fn    = OP_ADD;
      alu_b = (f_md == M_BASE) ? bus_b : '0;
    end
    case (fn)
      OP_AND:  alu_y = bus_a & alu_b;
      OP_OR:   alu_y = bus_a | alu_b;
      default: alu_y = bus_a + alu_b;
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_a <= '0;
      bus_b <= '0;
      ao    <= '0;
      ao_en <= 1'b0;
      do_en <= 1'b0;
      rd_o  <= 1'b0;
      wr_o  <= 1'b0;
    end else begin
      ao_en <= 1'b0;
      do_en <= 1'b0;
      rd_o  <= 1'b0;
      wr_o  <= 1'b0;
      case (state)
        S_FETCH, S_DISP: begin
          ao    <= pc;
          ao_en <= 1'b1;
          rd_o  <= 1'b1;
        end
        S_ADDR: begin
          bus_a <= (f_md == M_BASE) ? base : gpr[f_src];
          bus_b <= di;
        end
        S_READ: begin
          ao    <= t1;
          ao_en <= 1'b1;
          rd_o  <= 1'b1;
        end
        S_EXEC: begin
          bus_a <= gpr[f_dst];
          bus_b <= (f_md == M_REG) ? gpr[f_src] : di;
        end
        S_WB: begin
          bus_b <= (f_op == OP_LBI) ? di : t1;
          if (f_op != OP_LBI && mem_dst) begin
            ao    <= t2;
            ao_en <= 1'b1;
            do_en <= 1'b1;
            wr_o  <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FETCH;
      ir    <= '0;
      pc    <= '0;
      di    <= '0;
      t1    <= '0;
      t2    <= '0;
      base  <= '0;
      for (int i = 0; i < 4; i++) gpr[i] <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir <= dat_i[7:0];
          pc <= pc + 1'b1;
          if (dat_i[7:6] == OP_LBI || dat_i[5:4] == M_BASE) state <= S_DISP;
          else if (dat_i[5:4] == M_REG)                     state <= S_EXEC;
          else                                              state <= S_ADDR;
        end
        S_DISP: begin
          di    <= dat_i;
          pc    <= pc + 1'b1;
          state <= (f_op == OP_LBI) ? S_WB : S_ADDR;
        end
        S_ADDR: begin
          t1    <= alu_y;
          state <= S_READ;
        end
        S_READ: begin
          di    <= dat_i;
          t2    <= t1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          t1    <= alu_y;
          state <= S_WB;
        end
        S_WB: begin
          if (f_op == OP_LBI) base <= bus_b;
          else if (!mem_dst)  gpr[f_dst] <= bus_b;
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end
endmodule

module cisc_exec_core_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_o,
  input logic wr_o
);
  assert_no_rdwr_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));
  assert_write_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> !wr_o);
  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_o) |-> $past(rd_o, 2));
  assert_fetch_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o |=> rd_o);
endmodule

bind cisc_exec_core cisc_exec_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_o(rd_o), .wr_o(wr_o)
);

// File: tb/sim_cisc_exec_core.sv
module sim_cisc_exec_core;
  localparam int LIMIT = 3000;
  typedef struct packed { logic [1:0] md; logic [7:0] a; logic [7:0] d; logic [31:0] c; } wr_t;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] dat_i, dat_o, addr_o;
  logic       rd_o, wr_o;
  logic [7:0] mem [256];
  logic [7:0] mm  [256];
  wr_t        q[$];
  int         checks = 0, errors = 0, ptr = 0;

  always #10 clk = ~clk;
  always_comb dat_i = mem[addr_o];

  cisc_exec_core u0 (.clk(clk), .rst_n(rst_n), .dat_i(dat_i), .dat_o(dat_o),
                     .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    mem[ptr] = b; mm[ptr] = b; ptr++;
  endtask

  function automatic logic [7:0] f(input logic [1:0] op, input logic [7:0] x, input logic [7:0] y);
    case (op)
      2'd1:    return x & y;
      2'd2:    return x | y;
      default: return x + y;   // R7 modulo wrap
    endcase
  endfunction

  // driver: instruction-level reference, pushes each expected store
  task automatic drive_model(input int prog_end);
    logic [7:0] r [4];
    logic [7:0] b = 0, pc = 0, ir, a;
    logic [31:0] cyc = 0;
    for (int i = 0; i < 4; i++) r[i] = 0;
    while (int'(pc) < prog_end) begin
      ir = mm[pc];
      if (ir[7:6] == 2'd3) begin                        // R5
        b = mm[pc + 8'd1]; pc = pc + 8'd2; cyc += 3;
      end else if (ir[5:4] == 2'd0) begin               // R2
        r[ir[3:2]] = f(ir[7:6], r[ir[3:2]], r[ir[1:0]]); pc++; cyc += 3;
      end else if (ir[5:4] == 2'd3) begin               // R6
        r[ir[3:2]] = f(ir[7:6], r[ir[3:2]], mm[r[ir[1:0]]]); pc++; cyc += 5;
      end else if (ir[5:4] == 2'd1) begin               // R3
        a = r[ir[1:0]]; mm[a] = f(ir[7:6], r[ir[3:2]], mm[a]);
        q.push_back('{2'd1, a, mm[a], cyc + 4}); pc++; cyc += 5;
      end else begin                                    // R4
        a = b + mm[pc + 8'd1]; mm[a] = f(ir[7:6], r[ir[3:2]], mm[a]);
        q.push_back('{2'd2, a, mm[a], cyc + 5}); pc = pc + 8'd2; cyc += 6;
      end
    end
  endtask

  initial begin
    wr_t e;
    int  tail = 0, k = 0;
    for (int i = 0; i < 256; i++) begin mem[i] = 0; mm[i] = 0; end
    put(8'hB8); put(8'hB2); put(8'h08); put(8'hB6); put(8'h04); put(8'h08); // R6, R2, R7 wrap 7F+01
    put(8'hBE); put(8'h56); put(8'h1E);                                     // R3 AND then ADD
    put(8'hC0); put(8'hC0); put(8'h24); put(8'h05);                         // R5, R4
    put(8'hAC); put(8'h3F);                                                 // R4 to address FF
    put(8'hC0); put(8'hFF); put(8'h6C); put(8'h02);                         // R4 address wraps to 01
    put(8'h8D); put(8'h0F); put(8'h1E); put(8'h76); put(8'h96);             // R2 OR/ADD, R6 AND, R3 OR
    mem[8'hB8] = 8'h01; mm[8'hB8] = 8'h01; mem[8'hB9] = 8'h7F; mm[8'hB9] = 8'h7F;
    mem[8'hBA] = 8'h3C; mm[8'hBA] = 8'h3C; mem[8'hC5] = 8'h90; mm[8'hC5] = 8'h90;
    mem[8'hFF] = 8'h41; mm[8'hFF] = 8'h41;
    drive_model(ptr);

    repeat (3) @(posedge clk);
    #5;
    chk(!rd_o && !wr_o, "R1", "strobes in reset", {rd_o, wr_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // monitor: sample 2 ns before each rising edge
    while (k < LIMIT && (q.size() > 0 || tail < 30)) begin
      @(negedge clk); #8;
      if (k == 0) begin
        chk(rd_o == 1'b1, "R1", "first cycle read strobe", rd_o, 1);
        chk(addr_o == 8'h00, "R1", "first fetch address", addr_o, 0);
      end
      if (wr_o) begin
        if (q.size() == 0) chk(0, "R8", "unexpected write at address", addr_o, 0);
        else begin
          e = q.pop_front();
          chk(addr_o == e.a, e.md == 2'd1 ? "R3" : "R4", "write address", addr_o, e.a);
          chk(dat_o  == e.d, "R7", "write data", dat_o, e.d);
          chk(k == int'(e.c), "R9", "write cycle", k, e.c);
          mem[addr_o] = dat_o;
          #4;
          chk(wr_o && addr_o == e.a, "R10", "outputs stable across rising edge", addr_o, e.a);
        end
      end
      if (q.size() == 0) tail++;
      k++;
    end
    if (k >= LIMIT) chk(0, "R9", "watchdog expired, stores left", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule